// File: doc/BRIEF.md
# Serial Link Command Slot Decoder

This block sits on the codec side of a serial audio link. It watches the controller's outbound serial line on every falling edge of the bit clock. It lines itself up to each frame when the frame marker (SYNC) rises, then slices off the header slot, the command address slot and the command data slot. The audio slots that follow are not used.

From the header slot it keeps two tag flags and the two-bit target identity field. It then decides whether this codec should act on the register command carried in the frame. A primary codec (strapped identity 0) trusts only the tag flags. A secondary codec (identity 1, 2 or 3) does not look at the tags at all. It acts only when the frame's target field equals its own identity.

An accepted command appears as a one-clock strobe. The strobe comes with the read/write flag, the register index and, for writes, the data word. All three values stay on the outputs until the next accepted command.

The control path has five states:
- IDLE waits for a frame.
- TAG collects the 16-bit header.
- ADDR collects the 20-bit address slot.
- DATA collects the 20-bit data slot.
- REST lets the remaining 200 bits of the 256-bit frame go by.

The transitions are:
- Any state goes to TAG on a SYNC rise.
- TAG goes to ADDR after header bit 0.
- ADDR goes to DATA after 20 bits.
- DATA goes to REST after 20 bits, issuing the strobe if the command qualifies.
- REST goes to IDLE after 200 bits.

Top module: `acl_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted command, `cmd_stb`, `cmd_rd`, `cmd_idx` and `cmd_wdata` are all zero.
- R2: The identity is the bitwise inverse of `id_strap_n`. With both strap pins high (left open), the codec is primary (identity 0).
- R3: A frame starts at the falling-edge sample where `sync` is first seen high after being low. That sample is header bit 15. The header's 16 bits and each following 20-bit slot arrive most significant bit first, so a frame is 256 bits long.
- R4: A primary codec accepts a read (address slot bit 19 = 1) when header bit 14 (address valid) is 1, whatever header bits 1:0 hold.
- R5: A primary codec accepts a write (address slot bit 19 = 0) only when header bits 14 and 13 (data valid) are both 1. If either is 0, there is no strobe.
- R6: A secondary codec accepts a command, read or write, exactly when header bits 1:0 equal its identity. Header bits 14 and 13 have no effect.
- R7: On acceptance, `cmd_rd` = address slot bit 19 and `cmd_idx` = address slot bits 18:12. For a write, `cmd_wdata` = data slot bits 19:4.
- R8: `cmd_stb` is high for exactly one bit clock and at most once per frame. It is set at the falling edge that samples data slot bit 0, which is frame bit 55 counted from 0.
- R9: `cmd_rd`, `cmd_idx` and `cmd_wdata` change only together with a strobe. A frame that is not accepted leaves them unchanged, and an accepted read leaves `cmd_wdata` unchanged.
- R10: A SYNC rise in the middle of a frame abandons that frame without a strobe and starts a new frame at that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker from the controller |
| sdo | input | 1 | Serial data from the controller, MSB first |
| id_strap_n | input | 2 | Active-low identity straps; both high means primary |
| cmd_stb | output | 1 | One-clock pulse for an accepted register command |
| cmd_rd | output | 1 | 1 for a read command, 0 for a write |
| cmd_idx | output | 7 | Register index of the last accepted command |
| cmd_wdata | output | 16 | Data of the last accepted write |

## Verification
The assertions assume that the identity straps do not change while a frame is in flight. They also assume that once `sync` rises, it stays high long enough for the header bits to be sampled as one frame. The stimulus follows both rules. It changes the straps only between frames and holds `sync` high for the 16 header bits of every frame. It drives `sdo` and `sync` on the rising edge, so every falling-edge sample sees settled values. The mid-frame SYNC rise of R10 is applied only in one directed case, and it too is driven on a rising edge.

// File: rtl/acl_pkg.sv
package acl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_ADDR,
        ST_DATA,
        ST_REST
    } acl_state_e;

endpackage

// File: rtl/acl_shift_in.sv
// Free-running deserializer. Only the high window and the lowest bits are
// brought out; the middle bits exist just to carry data through.
module acl_shift_in #(
    parameter int W      = 19,
    parameter int LO_CUT = 3,
    parameter int LO_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                d,
    output logic [W-1:LO_CUT]   q_hi,
    output logic [LO_W-1:0]     q_lo
);

    logic [W-1:0] sr;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[W-2:0], d};
        end
    end

    assign q_hi = sr[W-1:LO_CUT];
    assign q_lo = sr[LO_W-1:0];

endmodule

// File: rtl/acl_frame_fsm.sv
// Frame sequencer: tracks which slot the current sample belongs to.
module acl_frame_fsm
    import acl_pkg::*;
#(
    parameter int SLOT0_BITS = 16,
    parameter int SLOT_BITS  = 20,
    parameter int FRAME_BITS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rise,
    output logic slot0_done,
    output logic slot1_done,
    output logic slot2_done
);

    localparam int REST_BITS = FRAME_BITS - SLOT0_BITS - 2 * SLOT_BITS;
    localparam int CNT_W     = $clog2(FRAME_BITS);

    acl_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt + 1'b1;
        slot0_done = 1'b0;
        slot1_done = 1'b0;
        slot2_done = 1'b0;
        if (sync_rise) begin
            // this sample is already header bit 15
            state_nx = ST_TAG;
            cnt_nx   = CNT_W'(1);
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_nx = '0;
                end
                ST_TAG: begin
                    if (cnt == CNT_W'(SLOT0_BITS - 1)) begin
                        slot0_done = 1'b1;
                        state_nx   = ST_ADDR;
                        cnt_nx     = '0;
                    end
                end
                ST_ADDR: begin
                    if (cnt == CNT_W'(SLOT_BITS - 1)) begin
                        slot1_done = 1'b1;
                        state_nx   = ST_DATA;
                        cnt_nx     = '0;
                    end
                end
                ST_DATA: begin
                    if (cnt == CNT_W'(SLOT_BITS - 1)) begin
                        slot2_done = 1'b1;
                        state_nx   = ST_REST;
                        cnt_nx     = '0;
                    end
                end
                ST_REST: begin
                    if (cnt == CNT_W'(REST_BITS - 1)) begin
                        state_nx = ST_IDLE;
                        cnt_nx   = '0;
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/acl_cmd_qual.sv
// Decides whether the frame's command is for this codec.
module acl_cmd_qual #(
    parameter int ID_W = 2
) (
    input  logic [ID_W-1:0] ident,
    input  logic            tag_addr,
    input  logic            tag_data,
    input  logic [ID_W-1:0] frame_id,
    input  logic            rd,
    output logic            accept
);

    always_comb begin
        if (ident == '0) begin
            accept = tag_addr && (rd || tag_data);
        end else begin
            accept = (frame_id == ident);
        end
    end

endmodule

// File: rtl/acl_cmd_decoder.sv
module acl_cmd_decoder
    import acl_pkg::*;
#(
    parameter int SLOT0_BITS = 16,
    parameter int SLOT_BITS  = 20,
    parameter int FRAME_BITS = 256,
    parameter int ID_W       = 2,
    parameter int IDX_W      = 7,
    parameter int DATA_W     = 16,
    parameter int TAG_A_BIT  = 14,
    parameter int TAG_D_BIT  = 13
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              sdo,
    input  logic [ID_W-1:0]   id_strap_n,
    output logic              cmd_stb,
    output logic              cmd_rd,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [DATA_W-1:0] cmd_wdata
);

    // After N-1 bits of an N-bit slot, slot bit b (b >= 1) sits at shift[b-1].
    localparam int SHIFT_W = SLOT_BITS - 1;
    localparam int LO_CUT  = SLOT_BITS - DATA_W - 1;
    localparam int LO_W    = ID_W - 1;
    localparam int RW_POS  = SLOT_BITS - 2;
    localparam int IDX_TOP = SLOT_BITS - 3;
    localparam int DAT_TOP = SLOT_BITS - 2;

    logic                  sync_q;
    logic                  sync_rise;
    logic [ID_W-1:0]       ident;
    logic [SHIFT_W-1:LO_CUT] sh_hi;
    logic [LO_W-1:0]       sh_lo;
    logic                  slot0_done, slot1_done, slot2_done;
    logic                  tag_a_q, tag_d_q;
    logic [ID_W-1:0]       fid_q;
    logic                  rd_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  accept;

    assign ident     = ~id_strap_n;
    assign sync_rise = sync && !sync_q;

    acl_shift_in #(
        .W      (SHIFT_W),
        .LO_CUT (LO_CUT),
        .LO_W   (LO_W)
    ) u_shift (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .d     (sdo),
        .q_hi  (sh_hi),
        .q_lo  (sh_lo)
    );

    acl_frame_fsm #(
        .SLOT0_BITS (SLOT0_BITS),
        .SLOT_BITS  (SLOT_BITS),
        .FRAME_BITS (FRAME_BITS)
    ) u_fsm (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .sync_rise  (sync_rise),
        .slot0_done (slot0_done),
        .slot1_done (slot1_done),
        .slot2_done (slot2_done)
    );

    acl_cmd_qual #(
        .ID_W (ID_W)
    ) u_qual (
        .ident    (ident),
        .tag_addr (tag_a_q),
        .tag_data (tag_d_q),
        .frame_id (fid_q),
        .rd       (rd_q),
        .accept   (accept)
    );

    // header and address field capture
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 1'b0;
            tag_a_q <= 1'b0;
            tag_d_q <= 1'b0;
            fid_q   <= '0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
        end else begin
            sync_q <= sync;
            if (slot0_done) begin
                tag_a_q <= sh_hi[TAG_A_BIT-1];
                tag_d_q <= sh_hi[TAG_D_BIT-1];
                fid_q   <= {sh_lo, sdo};
            end
            if (slot1_done) begin
                rd_q  <= sh_hi[RW_POS];
                idx_q <= sh_hi[IDX_TOP -: IDX_W];
            end
        end
    end

    // command outputs
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_stb   <= 1'b0;
            cmd_rd    <= 1'b0;
            cmd_idx   <= '0;
            cmd_wdata <= '0;
        end else begin
            cmd_stb <= slot2_done && accept;
            if (slot2_done && accept) begin
                cmd_rd  <= rd_q;
                cmd_idx <= idx_q;
                if (!rd_q) begin
                    cmd_wdata <= sh_hi[DAT_TOP -: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/acl_cmd_decoder_chk.sv
module acl_cmd_decoder_chk #(
    parameter int ID_W   = 2,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_stb,
    input logic              cmd_rd,
    input logic [IDX_W-1:0]  cmd_idx,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic [ID_W-1:0]   ident,
    input logic [ID_W-1:0]   fid_q,
    input logic              tag_a_q,
    input logic              tag_d_q
);

    // R8: single-clock pulse
    a_r8_stb_one_clock: assert property (@(negedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R9: fields move only with a strobe
    a_r9_hold_without_stb: assert property (@(negedge clk) disable iff (!rst_n)
        !cmd_stb |-> ($stable(cmd_rd) && $stable(cmd_idx) && $stable(cmd_wdata)));

    // R9: a read leaves the write data alone
    a_r9_read_keeps_wdata: assert property (@(negedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_rd) |-> $stable(cmd_wdata));

    // R6: secondary acts only on its own identity
    a_r6_secondary_match: assert property (@(negedge clk) disable iff (!rst_n)
        (cmd_stb && ident != '0) |-> (fid_q == ident));

    // R4, R5: primary obeys the tag flags
    a_r5_primary_tags: assert property (@(negedge clk) disable iff (!rst_n)
        (cmd_stb && ident == '0) |-> (tag_a_q && (cmd_rd || tag_d_q)));

endmodule

bind acl_cmd_decoder acl_cmd_decoder_chk #(
    .ID_W   (ID_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .cmd_stb   (cmd_stb),
    .cmd_rd    (cmd_rd),
    .cmd_idx   (cmd_idx),
    .cmd_wdata (cmd_wdata),
    .ident     (ident),
    .fid_q     (fid_q),
    .tag_a_q   (tag_a_q),
    .tag_d_q   (tag_d_q)
);

// File: tb/acl_cmd_decoder_tb.sv
`timescale 1ns/1ps
module acl_cmd_decoder_tb;

    typedef struct packed {
        logic [1:0]  ident;
        logic        ta;
        logic        td;
        logic [1:0]  fid;
        logic        rd;
        logic [6:0]  idx;
        logic [15:0] data;
        logic        acc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        {2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 7'h02, 16'h1234, 1'b1},
        {2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 7'h7C, 16'hFFFF, 1'b1},
        {2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 7'h10, 16'hAAAA, 1'b0},
        {2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 7'h04, 16'h0000, 1'b0},
        {2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 7'h20, 16'h5555, 1'b0},
        {2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 7'h26, 16'hBEEF, 1'b1},
        {2'd1, 1'b1, 1'b1, 2'd2, 1'b0, 7'h26, 16'hBEEF, 1'b0},
        {2'd2, 1'b1, 1'b1, 2'd2, 1'b1, 7'h3A, 16'h0F0F, 1'b1},
        {2'd3, 1'b0, 1'b0, 2'd3, 1'b0, 7'h7F, 16'h8001, 1'b1},
        {2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 7'h00, 16'h1111, 1'b0},
        {2'd2, 1'b0, 1'b1, 2'd1, 1'b0, 7'h55, 16'hC3C3, 1'b0},
        {2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 7'h01, 16'h0000, 1'b1}
    };

    logic        bit_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        sync    = 1'b0;
    logic        sdo     = 1'b0;
    logic [1:0]  id_strap_n = 2'b11;
    logic        cmd_stb;
    logic        cmd_rd;
    logic [6:0]  cmd_idx;
    logic [15:0] cmd_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    int bit_no = 0;
    int stb_cnt = 0;
    int stb_bit = -1;
    logic        cap_rd;
    logic [6:0]  cap_idx;
    logic [15:0] cap_wdata;
    logic        m_rd    = 1'b0;
    logic [6:0]  m_idx   = '0;
    logic [15:0] m_wdata = '0;
    bit done = 1'b0;

    always #5 bit_clk = ~bit_clk;

    acl_cmd_decoder u_dut (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .sync       (sync),
        .sdo        (sdo),
        .id_strap_n (id_strap_n),
        .cmd_stb    (cmd_stb),
        .cmd_rd     (cmd_rd),
        .cmd_idx    (cmd_idx),
        .cmd_wdata  (cmd_wdata)
    );

    // strobe monitor, sampled 1 ns after the rising edge
    always @(posedge bit_clk) begin
        #1;
        if (cmd_stb === 1'b1) begin
            stb_cnt   = stb_cnt + 1;
            stb_bit   = bit_no;
            cap_rd    = cmd_rd;
            cap_idx   = cmd_idx;
            cap_wdata = cmd_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic send_frame(input logic ta, input logic td, input logic [1:0] fid,
                              input logic rd, input logic [6:0] idx,
                              input logic [15:0] data, input int nbits);
        logic [255:0] fr;
        fr = '0;
        fr[255]     = 1'b1;
        fr[254]     = ta;
        fr[253]     = td;
        fr[241:240] = fid;
        fr[239]     = rd;
        fr[238:232] = idx;
        fr[231:220] = 12'hFFF;
        fr[219:204] = data;
        fr[203:200] = 4'hF;
        fr[199:0]   = {10{20'hA5A5A}};
        for (int i = 0; i < nbits; i++) begin
            @(posedge bit_clk);
            sync   = (i < 16);
            sdo    = fr[255 - i];
            bit_no = i;
        end
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge bit_clk);
            sync = 1'b0;
            sdo  = 1'b1;
            bit_no = -1;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge bit_clk);
        #2;
        check("R1 reset", {cmd_stb, cmd_rd, cmd_idx, cmd_wdata}, '0);
        @(posedge bit_clk);
        rst_n = 1'b1;
        idle_bits(5);
        #2;
        check("R1 after release", {cmd_stb, cmd_rd, cmd_idx, cmd_wdata}, '0);

        // table walk: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            string rq;
            id_strap_n = ~VECS[v].ident;
            stb_cnt = 0;
            stb_bit = -1;
            send_frame(VECS[v].ta, VECS[v].td, VECS[v].fid, VECS[v].rd,
                       VECS[v].idx, VECS[v].data, 256);
            rq = (VECS[v].ident != 2'd0) ? "R6" : (VECS[v].rd ? "R4" : "R5");
            check(rq, stb_cnt, {31'd0, VECS[v].acc});
            if (VECS[v].acc) begin
                check("R8 strobe bit", stb_bit, 56);
                check("R7 rd", cap_rd, VECS[v].rd);
                check("R7 idx", cap_idx, VECS[v].idx);
                if (!VECS[v].rd) begin
                    check("R7 wdata", cap_wdata, VECS[v].data);
                    m_wdata = VECS[v].data;
                end else begin
                    check("R9 read keeps wdata", cap_wdata, m_wdata);
                end
                m_rd  = VECS[v].rd;
                m_idx = VECS[v].idx;
            end else begin
                check("R9 held", {cmd_rd, cmd_idx, cmd_wdata}, {m_rd, m_idx, m_wdata});
            end
        end

        // R2: straps left high mean primary, so the target field is ignored
        id_strap_n = 2'b11;
        stb_cnt = 0;
        send_frame(1'b1, 1'b1, 2'd1, 1'b0, 7'h11, 16'h2222, 256);
        check("R2 open straps primary", stb_cnt, 1);
        check("R2 idx", cmd_idx, 7'h11);
        m_rd = 1'b0; m_idx = 7'h11; m_wdata = 16'h2222;

        // R3: idle gap, frame starts at SYNC rise
        idle_bits(37);
        stb_cnt = 0;
        stb_bit = -1;
        send_frame(1'b1, 1'b1, 2'd0, 1'b0, 7'h6B, 16'h9C3E, 256);
        check("R3 frame align bit", stb_bit, 56);
        check("R3 wdata", cap_wdata, 16'h9C3E);
        m_rd = 1'b0; m_idx = 7'h6B; m_wdata = 16'h9C3E;

        // R10: SYNC rises again inside the data slot
        stb_cnt = 0;
        stb_bit = -1;
        send_frame(1'b1, 1'b1, 2'd0, 1'b0, 7'h33, 16'h7777, 50);
        check("R10 no strobe from cut frame", stb_cnt, 0);
        send_frame(1'b1, 1'b1, 2'd0, 1'b0, 7'h44, 16'h4321, 256);
        check("R10 restart strobes once", stb_cnt, 1);
        check("R10 restart idx", cap_idx, 7'h44);
        check("R10 restart bit", stb_bit, 56);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge bit_clk);
        if (!done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule